// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block keeps the transmit and receive status of a byte-wide serial port and turns it into one interrupt request. It sits between a register bus and the serial shifters. It holds the byte waiting to be sent and the byte most recently received. Serialisation itself happens outside the block. The shifters report through single-cycle event pulses: the transmit shifter has taken the holding byte, the last bit has left the line, or a received byte is ready together with its parity and framing verdicts.

Software sees six registers on a simple read/write strobe interface:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | status | read-only |
| 2 | error status | read/write |
| 3 | interrupt mask | read/write |
| 4 | transmit data | write |
| 5 | receive data | read |

Reading the receive data register has side effects: it releases the receive buffer and clears every latched receive error. A summary bit reports when any error is held. Each of four sources, gated by its own mask bit, can raise the interrupt line. A parameter selects whether that line comes straight from the flags or through one register stage.

Top module: `uart_stat_ctrl`

## Requirements
- R1: After reset the status register reads 0x03 (both transmit-empty flags set), control and mask read 0, and `irq` is low.
- R2: The status register bit positions are as follows: bit 0 is transmit holding empty (TBE), bit 1 is transmit shifter empty (TSBE), bit 2 is receive buffer full (RBF), bit 3 is parity error, bit 4 is framing error, bit 5 is overrun and bit 6 is the error summary. Bits above 6 read 0.
- R3: The control register bits are as follows: bit 0 is transmit enable and bit 1 is receive enable. Writing 1 to bit 2 empties the transmit holding register, so TBE reads 1 on the next cycle. Bit 2 always reads back as 0.
- R4: Writing the transmit data register (address 4) loads `tx_data` and clears TBE. `tx_req` is high while TBE is 0 and transmit enable is set. A `tx_load` pulse while `tx_req` is high sets TBE and clears TSBE. A `tx_done` pulse sets TSBE.
- R5: A `rx_strobe` pulse while receive enable is set stores `rx_byte`, sets RBF and latches `rx_par_err` into bit 3 and `rx_frm_err` into bit 4. While receive enable is clear, the pulse is ignored.
- R6: A byte that arrives while RBF is set and the receive data register is not being read sets overrun. The held byte and its parity and framing flags stay unchanged.
- R7: Reading the receive data register (address 5) returns the held byte in the low bits. On the next cycle RBF and all error flags read 0.
- R8: Writing zero to the error status register (address 2) clears the parity, framing and overrun flags and leaves RBF as it is. A nonzero write has no effect. Reading this register returns the error bits at the same positions as in the status register.
- R9: The summary bit (bit 6) is 1 exactly when at least one of the parity, framing or overrun flags is 1.
- R10: The mask register keeps only bits 0, 1, 2 and 6, and reads its other bits as 0. `irq` is the OR over those four positions of status bit AND mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers read side effects) |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr`, combinational |
| tx_data | output | DATA_W | Transmit holding byte |
| tx_req | output | 1 | Holding byte is waiting and transmit is enabled |
| tx_load | input | 1 | Shifter took the holding byte |
| tx_done | input | 1 | Shifter has sent its last bit |
| rx_strobe | input | 1 | A received byte is ready |
| rx_byte | input | DATA_W | Received byte |
| rx_par_err | input | 1 | Parity error for this byte |
| rx_frm_err | input | 1 | Framing error for this byte |
| tx_en | output | 1 | Transmit enable control bit |
| rx_en | output | 1 | Receive enable control bit |
| irq | output | 1 | Interrupt request |

## Verification
The receive path is driven by a table of arrivals. Each arrival is either preceded by a read of the receive data register or sent while the buffer is still full. Clean bytes, parity-only bytes, framing-only bytes and bytes with both errors are mixed. The table therefore tells an accepted byte from one that overruns: in the overrun case the returned data must still be the older byte, and the error flags belong to the byte actually kept.

Directed cases cover the following:
- a transmit write, then a shifter load, then completion;
- the holding-clear bit;
- arrivals with receive disabled;
- nonzero and zero writes to the error register;
- interrupt masks that select a set flag, a clear flag, or nothing.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;

   localparam int unsigned BIT_TBE  = 0;
   localparam int unsigned BIT_TSBE = 1;
   localparam int unsigned BIT_RBF  = 2;
   localparam int unsigned BIT_PAR  = 3;
   localparam int unsigned BIT_FRM  = 4;
   localparam int unsigned BIT_OVR  = 5;
   localparam int unsigned BIT_SUM  = 6;
   localparam int unsigned STAT_W   = 7;

   localparam int unsigned CB_TXEN  = 0;
   localparam int unsigned CB_RXEN  = 1;
   localparam int unsigned CB_TXCLR = 2;

   localparam int unsigned RA_CTRL  = 0;
   localparam int unsigned RA_STAT  = 1;
   localparam int unsigned RA_ERR   = 2;
   localparam int unsigned RA_MASK  = 3;
   localparam int unsigned RA_TXD   = 4;
   localparam int unsigned RA_RXD   = 5;

   localparam int unsigned IRQ_SRCS = 4;

   typedef struct packed {
      logic sum;
      logic ovr;
      logic frm;
      logic par;
      logic rbf;
      logic tsbe;
      logic tbe;
   } stat_t;

endpackage

// File: rtl/uart_stat_txq.sv
module uart_stat_txq #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_txd,
   input  logic [DATA_W-1:0] wdata,
   input  logic              hold_clr,
   input  logic              tx_en,
   input  logic              tx_load,
   input  logic              tx_done,
   output logic              tbe,
   output logic              tsbe,
   output logic [DATA_W-1:0] hold,
   output logic              tx_req
);

   logic take;

   assign tx_req = ~tbe & tx_en;
   assign take   = tx_load & tx_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbe  <= 1'b1;
         hold <= '0;
      end else if (hold_clr) begin
         tbe  <= 1'b1;
      end else if (wr_txd) begin
         tbe  <= 1'b0;
         hold <= wdata;
      end else if (take) begin
         tbe  <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tsbe <= 1'b1;
      else if (take)    tsbe <= 1'b0;
      else if (tx_done) tsbe <= 1'b1;
   end

endmodule

// File: rtl/uart_stat_rxq.sv
module uart_stat_rxq #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_strobe,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   input  logic              rx_en,
   input  logic              rd_rxd,
   input  logic              err_clr,
   output logic              rbf,
   output logic              par,
   output logic              frm,
   output logic              ovr,
   output logic [DATA_W-1:0] hold
);

   logic accept, busy, store, drop;

   assign accept = rx_strobe & rx_en;
   assign busy   = rbf & ~rd_rxd;
   assign store  = accept & ~busy;
   assign drop   = accept & busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbf  <= 1'b0;
         hold <= '0;
      end else if (store) begin
         rbf  <= 1'b1;
         hold <= rx_byte;
      end else if (rd_rxd) begin
         rbf  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         par <= 1'b0;
         frm <= 1'b0;
      end else if (store) begin
         par <= rx_par_err;
         frm <= rx_frm_err;
      end else if (rd_rxd || err_clr) begin
         par <= 1'b0;
         frm <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovr <= 1'b0;
      else if (drop)              ovr <= 1'b1;
      else if (rd_rxd || err_clr) ovr <= 1'b0;
   end

endmodule

// File: rtl/uart_stat_irqc.sv
module uart_stat_irqc #(
   parameter int unsigned NSRC       = 4,
   parameter bit          REGISTERED = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] flags,
   input  logic [NSRC-1:0] mask,
   output logic            irq
);

   logic [NSRC-1:0] hit;
   logic            any;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit[i] = flags[i] & mask[i];
   end

   assign any = |hit;

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = any;
   end

endmodule

// File: rtl/uart_stat_ctrl.sv
module uart_stat_ctrl
   import uart_stat_pkg::*;
#(
   parameter int unsigned DATA_W         = 8,
   parameter int unsigned REG_W          = 16,
   parameter int unsigned ADDR_W         = 4,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_req,
   input  logic              tx_load,
   input  logic              tx_done,
   input  logic              rx_strobe,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_par_err,
   input  logic              rx_frm_err,
   output logic              tx_en,
   output logic              rx_en,
   output logic              irq
);

   localparam int unsigned PAD_W = REG_W - STAT_W;

   if (DATA_W > REG_W) begin : g_chk_data
      $error("DATA_W must not exceed REG_W");
   end
   if (REG_W < STAT_W) begin : g_chk_reg
      $error("REG_W too narrow for the status layout");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("ADDR_W must reach six registers");
   end

   logic sel_ctrl, sel_stat, sel_err, sel_mask, sel_txd, sel_rxd;
   assign sel_ctrl = reg_addr == ADDR_W'(RA_CTRL);
   assign sel_stat = reg_addr == ADDR_W'(RA_STAT);
   assign sel_err  = reg_addr == ADDR_W'(RA_ERR);
   assign sel_mask = reg_addr == ADDR_W'(RA_MASK);
   assign sel_txd  = reg_addr == ADDR_W'(RA_TXD);
   assign sel_rxd  = reg_addr == ADDR_W'(RA_RXD);

   logic wr_ctrl, wr_err0, wr_mask, wr_txd, rd_rxd, hold_clr;
   assign wr_ctrl  = reg_wr & sel_ctrl;
   assign wr_err0  = reg_wr & sel_err & (reg_wdata == '0);
   assign wr_mask  = reg_wr & sel_mask;
   assign wr_txd   = reg_wr & sel_txd;
   assign rd_rxd   = reg_rd & sel_rxd;
   assign hold_clr = wr_ctrl & reg_wdata[CB_TXCLR];

   logic tx_en_q, rx_en_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en_q <= 1'b0;
         rx_en_q <= 1'b0;
      end else if (wr_ctrl) begin
         tx_en_q <= reg_wdata[CB_TXEN];
         rx_en_q <= reg_wdata[CB_RXEN];
      end
   end
   assign tx_en = tx_en_q;
   assign rx_en = rx_en_q;

   logic [IRQ_SRCS-1:0] mask_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (wr_mask) mask_q <= {reg_wdata[BIT_SUM], reg_wdata[BIT_RBF],
                                   reg_wdata[BIT_TSBE], reg_wdata[BIT_TBE]};
   end

   logic              tbe_w, tsbe_w;
   logic [DATA_W-1:0] tx_hold_w;

   uart_stat_txq #(.DATA_W(DATA_W)) u_txq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_txd   (wr_txd),
      .wdata    (reg_wdata[DATA_W-1:0]),
      .hold_clr (hold_clr),
      .tx_en    (tx_en_q),
      .tx_load  (tx_load),
      .tx_done  (tx_done),
      .tbe      (tbe_w),
      .tsbe     (tsbe_w),
      .hold     (tx_hold_w),
      .tx_req   (tx_req)
   );
   assign tx_data = tx_hold_w;

   logic              rbf_w, par_w, frm_w, ovr_w;
   logic [DATA_W-1:0] rx_hold_w;

   uart_stat_rxq #(.DATA_W(DATA_W)) u_rxq (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_strobe  (rx_strobe),
      .rx_byte    (rx_byte),
      .rx_par_err (rx_par_err),
      .rx_frm_err (rx_frm_err),
      .rx_en      (rx_en_q),
      .rd_rxd     (rd_rxd),
      .err_clr    (wr_err0),
      .rbf        (rbf_w),
      .par        (par_w),
      .frm        (frm_w),
      .ovr        (ovr_w),
      .hold       (rx_hold_w)
   );

   stat_t stat_w;
   always_comb begin
      stat_w.tbe  = tbe_w;
      stat_w.tsbe = tsbe_w;
      stat_w.rbf  = rbf_w;
      stat_w.par  = par_w;
      stat_w.frm  = frm_w;
      stat_w.ovr  = ovr_w;
      stat_w.sum  = par_w | frm_w | ovr_w;
   end

   uart_stat_irqc #(.NSRC(IRQ_SRCS), .REGISTERED(IRQ_REGISTERED)) u_irqc (
      .clk   (clk),
      .rst_n (rst_n),
      .flags ({stat_w.sum, stat_w.rbf, stat_w.tsbe, stat_w.tbe}),
      .mask  (mask_q),
      .irq   (irq)
   );

   logic [STAT_W-1:0] stat_bits, err_bits, mask_bits;
   assign stat_bits = stat_w;
   assign err_bits  = stat_bits & STAT_W'(7'h78);
   always_comb begin
      mask_bits           = '0;
      mask_bits[BIT_TBE]  = mask_q[0];
      mask_bits[BIT_TSBE] = mask_q[1];
      mask_bits[BIT_RBF]  = mask_q[2];
      mask_bits[BIT_SUM]  = mask_q[3];
   end

   always_comb begin
      reg_rdata = '0;
      if (sel_ctrl) begin
         reg_rdata[CB_TXEN] = tx_en_q;
         reg_rdata[CB_RXEN] = rx_en_q;
      end else if (sel_stat) begin
         reg_rdata = {{PAD_W{1'b0}}, stat_bits};
      end else if (sel_err) begin
         reg_rdata = {{PAD_W{1'b0}}, err_bits};
      end else if (sel_mask) begin
         reg_rdata = {{PAD_W{1'b0}}, mask_bits};
      end else if (sel_rxd) begin
         reg_rdata[DATA_W-1:0] = rx_hold_w;
      end
   end

endmodule

// File: rtl/uart_stat_ctrl_chk.sv
module uart_stat_ctrl_chk
   import uart_stat_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned REG_W  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [REG_W-1:0]  reg_wdata,
   input logic              rx_strobe,
   input logic              rx_en,
   input logic [STAT_W-1:0] stat,
   input logic [DATA_W-1:0] rx_hold,
   input logic [3:0]        mask,
   input logic              irq
);

   logic rd_rx, wr_tx, wr_clr, drop;
   assign rd_rx  = reg_rd && reg_addr == ADDR_W'(RA_RXD);
   assign wr_tx  = reg_wr && reg_addr == ADDR_W'(RA_TXD);
   assign wr_clr = reg_wr && reg_addr == ADDR_W'(RA_CTRL) && reg_wdata[CB_TXCLR];
   assign drop   = rx_strobe && rx_en && stat[BIT_RBF] && !rd_rx;

   AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rx && !rx_strobe) |=> (stat[BIT_RBF] == 1'b0 && stat[BIT_OVR:BIT_PAR] == 3'b000)); // R7

   AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> stat[BIT_OVR]); // R6

   AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> $stable(rx_hold)); // R6

   AST_TXCLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> stat[BIT_TBE]); // R3

   AST_TXD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_tx && !wr_clr) |=> !stat[BIT_TBE]); // R4

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 4'd0 && $past(mask) == 4'd0) |-> !irq); // R10

endmodule

bind uart_stat_ctrl uart_stat_ctrl_chk #(
   .DATA_W (DATA_W),
   .REG_W  (REG_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .rx_strobe (rx_strobe),
   .rx_en     (rx_en_q),
   .stat      (stat_bits),
   .rx_hold   (rx_hold_w),
   .mask      (mask_q),
   .irq       (irq)
);

// File: tb/uart_stat_ctrl_bench.sv
module uart_stat_ctrl_bench;

   localparam int DATA_W = 8;
   localparam int REG_W  = 16;
   localparam int ADDR_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0, reg_rd = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [REG_W-1:0]  reg_wdata = '0;
   logic [REG_W-1:0]  reg_rdata;
   logic [DATA_W-1:0] tx_data;
   logic              tx_req, tx_en, rx_en, irq;
   logic              tx_load = 1'b0, tx_done = 1'b0;
   logic              rx_strobe = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
   logic [DATA_W-1:0] rx_byte = '0;

   int n_cmp = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   uart_stat_ctrl u_uart_stat_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .tx_data(tx_data), .tx_req(tx_req), .tx_load(tx_load), .tx_done(tx_done),
      .rx_strobe(rx_strobe), .rx_byte(rx_byte), .rx_par_err(rx_par_err),
      .rx_frm_err(rx_frm_err), .tx_en(tx_en), .rx_en(rx_en), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [REG_W-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [REG_W-1:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = ADDR_W'(a);
      #1 d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic rx(input logic [7:0] b, input logic p, input logic f);
      @(negedge clk);
      rx_strobe = 1'b1; rx_byte = b; rx_par_err = p; rx_frm_err = f;
      @(posedge clk); #1;
      rx_strobe = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
   endtask

   task automatic pulse_load();
      @(negedge clk); tx_load = 1'b1; @(posedge clk); #1 tx_load = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); tx_done = 1'b1; @(posedge clk); #1 tx_done = 1'b0;
   endtask

   // {read_first, expected returned byte, arriving byte, parity, framing, expected status}
   localparam logic [25:0] TBL [7] = '{
      {1'b1, 8'h00, 8'h11, 1'b0, 1'b0, 7'h07},
      {1'b0, 8'h00, 8'h22, 1'b0, 1'b0, 7'h67},
      {1'b1, 8'h11, 8'h33, 1'b1, 1'b0, 7'h4F},
      {1'b1, 8'h33, 8'h44, 1'b0, 1'b1, 7'h57},
      {1'b1, 8'h44, 8'h55, 1'b1, 1'b1, 7'h5F},
      {1'b0, 8'h00, 8'h66, 1'b0, 1'b0, 7'h7F},
      {1'b1, 8'h55, 8'h77, 1'b0, 1'b0, 7'h07}
   };

   initial begin : watchdog
      #1600000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [REG_W-1:0] d;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(1, d); check("R1 stat", d, 16'h0003);
      rd(0, d); check("R1 ctrl", d, 16'h0000);
      rd(3, d); check("R1 mask", d, 16'h0000);
      check("R1 irq", irq, 0);

      // R5 receive disabled: arrival ignored
      rx(8'h9A, 1'b1, 1'b1);
      rd(1, d); check("R5 ignored while disabled", d, 16'h0003);

      // R2 R5 R6 R7 R9 vector table
      wr(0, 16'h0002);
      check("R3 rx_en", rx_en, 1);
      for (int i = 0; i < 7; i++) begin
         logic [25:0] v;
         v = TBL[i];
         if (v[25]) begin
            rd(5, d);
            check($sformatf("R7 data entry %0d", i), d, {8'h00, v[24:17]});
         end
         rx(v[16:9], v[8], v[7]);
         rd(1, d);
         check($sformatf("R2 R6 R9 stat entry %0d", i), d, {9'h000, v[6:0]});
      end
      rd(5, d); check("R7 last byte", d, 16'h0077);
      rd(1, d); check("R7 cleared", d, 16'h0003);

      // R8 error register clear
      rx(8'hC3, 1'b1, 1'b0);
      wr(2, 16'h0008);
      rd(2, d); check("R8 nonzero write no effect", d, 16'h0048);
      wr(2, 16'h0000);
      rd(1, d); check("R8 zero write clears errors keeps RBF", d, 16'h0007);

      // R10 interrupt masks (status now 0x07)
      wr(3, 16'hFFFF);
      rd(3, d); check("R10 mask readback", d, 16'h0047);
      wr(3, 16'h0040); #1 check("R10 irq summary masked only", irq, 0);
      wr(3, 16'h0004); #1 check("R10 irq rbf", irq, 1);
      rd(5, d);        #1 check("R10 irq drops after read", irq, 0);
      rx(8'h01, 1'b0, 1'b1);
      wr(3, 16'h0040); #1 check("R10 R9 irq summary", irq, 1);
      wr(3, 16'h0000); #1 check("R10 irq none", irq, 0);
      rd(5, d);

      // R4 transmit sequence
      wr(0, 16'h0003);
      wr(4, 16'h00A5);
      rd(1, d); check("R4 TBE cleared", d, 16'h0002);
      check("R4 tx_data", tx_data, 8'hA5);
      check("R4 tx_req", tx_req, 1);
      pulse_load();
      rd(1, d); check("R4 load", d, 16'h0001);
      check("R4 tx_req low", tx_req, 0);
      pulse_done();
      rd(1, d); check("R4 done", d, 16'h0003);

      // R3 holding clear
      wr(4, 16'h005A);
      wr(0, 16'h0007);
      rd(1, d); check("R3 clear sets TBE", d, 16'h0003);
      rd(0, d); check("R3 clear bit reads 0", d, 16'h0003);
      check("R3 tx_req after clear", tx_req, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule